// File: doc/BRIEF.md
# Video-Memory Block Copy Engine

This engine copies data into the 8 KiB video-memory window (0x8000 to 0x9FFF) in units of 16-byte blocks. Software loads a source pointer, a destination offset and a control word. The control word gives the block count and picks one of two modes. In burst mode every block is copied at once while the processor is held. In line-blank mode the engine waits for a visible horizontal-blank interval and copies exactly one block in each such interval. The processor is also held during that block.

Byte pacing follows a speed flag. A normal-speed copy moves one byte every 2 cycles. A double-speed copy moves one byte every 4 cycles. The processor hold ends 5 cycles after the last byte. A block is counted as finished in the readable status, and the pointers step past it, only 12 cycles after its last byte. The engine therefore keeps running after the hold has dropped, until every copied block has been counted. A duration output reports the length of the most recent run in display dots, which are halved in double speed.

Top module: `vblk_dma`

## Requirements
- R1: `cfg_sel` picks a register: 0 is the source, 1 is the destination and 2 is the control word. In the control word, bits 6:0 hold the block count minus one and bit 7 selects the mode (0 = burst, 1 = line-blank). Each block is 16 bytes. A burst copies all of its blocks back to back in ascending byte order.
- R2: Bits 3:0 of a source write are ignored. The destination offset is taken from bits 12:4 of its write, with bits 3:0 as zero. Byte j of a run is written to `wr_addr` = 0x8000 + ((offset + j) mod 0x2000), so the address wraps inside the window.
- R3: Count the cycle in which a run is triggered as cycle 0. Its first byte is written in cycle 2 and each later byte 2 cycles after the previous one. With `dbl_speed` high at the trigger, both values are 4.
- R4: `cpu_stall` is high from cycle 1 to cycle D + (16N − 1)·P + 5 inclusive. Here N is the number of blocks in the run, D is the first-byte delay and P is the byte spacing.
- R5: `status` reads 0xFF when no transfer is pending. Otherwise bit 7 is 0 and bits 6:0 hold the number of blocks not yet counted as finished, minus one.
- R6: A block counts as finished in the cycle 12 cycles after its last byte is written. `status` shows the change one cycle later. At that point the source pointer and the destination offset each advance by 16, so a later transfer continues from there.
- R7: A line-blank block starts only in a cycle where all of these hold: `lcd_on` is 1, `line_num` < 144, `disp_mode` = 0 (horizontal blank) and `line_dot` > `blank_dot` + 2.
- R8: Once a block has been served on a line number, the engine does not serve that same line number again while its inputs stay on that line.
- R9: While `lcd_on` is 0, no line-blank block starts, whatever the other display inputs are.
- R10: A control write with bit 7 = 0 while a line-blank transfer is waiting cancels it. `status` becomes 0xFF and no more blocks are copied.
- R11: Register writes are ignored while a run is in flight, that is, from its trigger until its last block is counted.
- R12: A source byte whose address lies in 0x8000 to 0x9FFF or in 0xE000 to 0xFFFF is written as 0xFF. Any other source byte is copied from `rd_data`, which is sampled in the cycle where `rd_en` is high.
- R13: `run_dots` holds T = D + (16N − 1)·P + 5 for the latest run in normal speed, and ⌈T/2⌉ in double speed. It is loaded at the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 source, 1 destination, 2 control) |
| cfg_wdata | input | 16 | Register write data |
| lcd_on | input | 1 | Display enabled |
| disp_mode | input | 2 | Display mode; 0 is horizontal blank |
| line_num | input | 8 | Current display line |
| line_dot | input | 9 | Dot position within the line |
| blank_dot | input | 9 | Dot at which the current blank began |
| dbl_speed | input | 1 | Double-speed flag, sampled at each trigger |
| rd_en | output | 1 | Source read strobe |
| rd_addr | output | 16 | Source byte address |
| rd_data | input | 8 | Source byte, same cycle |
| wr_en | output | 1 | Video-memory write strobe |
| wr_addr | output | 16 | Video-memory write address |
| wr_data | output | 8 | Video-memory write data |
| cpu_stall | output | 1 | Processor hold |
| status | output | 8 | Remaining-length status |
| run_dots | output | 15 | Latest run length in display dots |

## Verification
Burst copies are swept over 1, 2, 3, 4 and 128 blocks at both speeds. Every cycle is compared for write timing, addresses, data, hold and status. This separates the first-byte delay from the byte spacing and the hold tail from the publish delay. A wrapping destination and unreadable source regions show whether the address wrap and the 0xFF substitution apply. Line-blank runs pass through display-off, line-144, non-blank and dot-guard inputs, then repeat a line, cancel, and run one double-speed block. A back-to-back burst with writes injected mid-run shows whether the pointers carry forward and whether writes during a run are ignored.

// File: rtl/vblk_dma_pkg.sv
package vblk_dma_pkg;

    localparam int BLK_BYTES   = 16;
    localparam int LEN_W       = 7;
    localparam int FIRST_NORM  = 2;
    localparam int STEP_NORM   = 2;
    localparam int RELEASE_CYC = 5;
    localparam int PUBLISH_CYC = 12;
    localparam int VIS_LINES   = 144;
    localparam int DOT_GUARD   = 2;
    localparam int MAX_BLOCKS  = 1 << LEN_W;
    localparam int CNT_W = $clog2(MAX_BLOCKS * BLK_BYTES * STEP_NORM * 2 + PUBLISH_CYC + FIRST_NORM * 2) + 1;

    localparam logic [1:0] SEL_SRC = 2'd0;
    localparam logic [1:0] SEL_DST = 2'd1;
    localparam logic [1:0] SEL_CTL = 2'd2;
    localparam logic [1:0] MODE_HBLANK = 2'd0;

    typedef enum logic [1:0] {ST_IDLE, ST_BURST, ST_LB_WAIT, ST_LB_RUN} eng_state_t;
    typedef enum logic [1:0] {WIN_NONE, WIN_LCD_OFF, WIN_BLANK} win_kind_t;

    typedef struct packed {
        win_kind_t  kind;
        logic [7:0] line;
    } win_t;

    function automatic int first_delay(input logic dbl);
        return dbl ? FIRST_NORM * 2 : FIRST_NORM;
    endfunction

    function automatic int byte_step(input logic dbl);
        return dbl ? STEP_NORM * 2 : STEP_NORM;
    endfunction

    function automatic int busy_cycles(input int nbytes, input logic dbl);
        if (nbytes == 0) return 0;
        return first_delay(dbl) + (nbytes - 1) * byte_step(dbl) + RELEASE_CYC;
    endfunction

    function automatic int disp_dots(input int cyc, input logic dbl);
        return dbl ? (cyc + 1) / 2 : cyc;
    endfunction

    function automatic logic src_readable(input logic [15:0] a);
        return !(a[15:13] == 3'b100 || a[15:13] == 3'b111);
    endfunction

endpackage

// File: rtl/vblk_dma_window.sv
module vblk_dma_window
    import vblk_dma_pkg::*;
(
    input  logic       lcd_on,
    input  logic [1:0] disp_mode,
    input  logic [7:0] line_num,
    input  logic [8:0] line_dot,
    input  logic [8:0] blank_dot,
    output win_t       win
);
    logic [9:0] guard_dot;

    always_comb begin
        guard_dot = {1'b0, blank_dot} + 10'(DOT_GUARD);
        win.line  = line_num;
        if (!lcd_on)
            win.kind = WIN_LCD_OFF;
        else if (line_num < 8'(VIS_LINES) && disp_mode == MODE_HBLANK &&
                 {1'b0, line_dot} > guard_dot)
            win.kind = WIN_BLANK;
        else
            win.kind = WIN_NONE;
    end
endmodule

// File: rtl/vblk_dma_pacer.sv
module vblk_dma_pacer
    import vblk_dma_pkg::*;
#(
    parameter int BW = LEN_W + 1,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          dbl,
    input  logic [BW-1:0] nblk,
    output logic          stall,
    output logic          wr_fire,
    output logic          pub_fire,
    output logic          last_pub,
    output logic [BW+3:0] byte_idx
);
    localparam int IW = BW + 4;

    logic          act;
    logic [CW-1:0] cnt, wr_at, pub_at, stall_end, step_r;
    logic [IW-1:0] bytes_left;
    logic [BW-1:0] pub_left;

    assign wr_fire  = act && bytes_left != '0 && cnt == wr_at;
    assign pub_fire = act && pub_left != '0 && cnt == pub_at;
    assign last_pub = pub_fire && pub_left == BW'(1);
    assign stall    = act && cnt <= stall_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            act        <= 1'b0;
            cnt        <= '0;
            wr_at      <= '0;
            pub_at     <= '0;
            stall_end  <= '0;
            step_r     <= '0;
            bytes_left <= '0;
            pub_left   <= '0;
            byte_idx   <= '0;
        end else if (start) begin
            act        <= 1'b1;
            cnt        <= CW'(1);
            wr_at      <= CW'(first_delay(dbl));
            pub_at     <= CW'(first_delay(dbl) + (BLK_BYTES - 1) * byte_step(dbl) + PUBLISH_CYC);
            stall_end  <= CW'(busy_cycles(int'(nblk) * BLK_BYTES, dbl));
            step_r     <= CW'(byte_step(dbl));
            bytes_left <= IW'(int'(nblk) * BLK_BYTES);
            pub_left   <= nblk;
            byte_idx   <= '0;
        end else if (act) begin
            cnt <= cnt + CW'(1);
            if (wr_fire) begin
                wr_at      <= wr_at + step_r;
                bytes_left <= bytes_left - IW'(1);
                byte_idx   <= byte_idx + IW'(1);
            end
            if (pub_fire) begin
                pub_at   <= pub_at + CW'(BLK_BYTES) * step_r;
                pub_left <= pub_left - BW'(1);
                if (last_pub) act <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vblk_dma.sv
module vblk_dma
    import vblk_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [15:0]       cfg_wdata,
    input  logic              lcd_on,
    input  logic [1:0]        disp_mode,
    input  logic [7:0]        line_num,
    input  logic [8:0]        line_dot,
    input  logic [8:0]        blank_dot,
    input  logic              dbl_speed,
    output logic              rd_en,
    output logic [15:0]       rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [15:0]       wr_addr,
    output logic [7:0]        wr_data,
    output logic              cpu_stall,
    output logic [LEN_W:0]    status,
    output logic [CNT_W-1:0]  run_dots
);
    localparam int BW = LEN_W + 1;
    localparam int IW = BW + 4;

    eng_state_t    state;
    win_t          win;
    logic [15:0]   src_ptr, run_src;
    logic [12:0]   dst_off, run_dst;
    logic [BW-1:0] blocks_left, p_nblk;
    logic [7:0]    last_line;
    logic          last_ok;
    logic          in_run, reg_ok, gp_go, lb_go, p_start;
    logic          wr_fire, pub_fire, last_pub;
    logic [IW-1:0] byte_idx;

    vblk_dma_window u_win (
        .lcd_on    (lcd_on),
        .disp_mode (disp_mode),
        .line_num  (line_num),
        .line_dot  (line_dot),
        .blank_dot (blank_dot),
        .win       (win)
    );

    always_comb begin
        in_run  = state == ST_BURST || state == ST_LB_RUN;
        reg_ok  = cfg_we && !in_run;
        gp_go   = reg_ok && cfg_sel == SEL_CTL && !cfg_wdata[LEN_W] && state == ST_IDLE;
        lb_go   = state == ST_LB_WAIT && !reg_ok && win.kind == WIN_BLANK &&
                  !(last_ok && last_line == win.line);
        p_start = gp_go || lb_go;
        p_nblk  = gp_go ? BW'(cfg_wdata[LEN_W-1:0]) + BW'(1) : BW'(1);
    end

    vblk_dma_pacer #(.BW(BW), .CW(CNT_W)) u_pace (
        .clk      (clk),
        .rst      (rst),
        .start    (p_start),
        .dbl      (dbl_speed),
        .nblk     (p_nblk),
        .stall    (cpu_stall),
        .wr_fire  (wr_fire),
        .pub_fire (pub_fire),
        .last_pub (last_pub),
        .byte_idx (byte_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            src_ptr     <= '0;
            dst_off     <= '0;
            blocks_left <= '0;
            last_line   <= '0;
            last_ok     <= 1'b0;
            run_src     <= '0;
            run_dst     <= '0;
            run_dots    <= '0;
        end else begin
            if (p_start) begin
                run_src  <= src_ptr;
                run_dst  <= dst_off;
                run_dots <= CNT_W'(disp_dots(busy_cycles(int'(p_nblk) * BLK_BYTES, dbl_speed), dbl_speed));
            end
            if (reg_ok) begin
                case (cfg_sel)
                    SEL_SRC: src_ptr <= {cfg_wdata[15:4], 4'h0};
                    SEL_DST: dst_off <= {cfg_wdata[12:4], 4'h0};
                    SEL_CTL: begin
                        if (cfg_wdata[LEN_W]) begin
                            state       <= ST_LB_WAIT;
                            blocks_left <= BW'(cfg_wdata[LEN_W-1:0]) + BW'(1);
                            last_ok     <= 1'b0;
                        end else if (state == ST_LB_WAIT) begin
                            state       <= ST_IDLE;
                            blocks_left <= '0;
                        end else begin
                            state       <= ST_BURST;
                            blocks_left <= BW'(cfg_wdata[LEN_W-1:0]) + BW'(1);
                        end
                    end
                    default: ;
                endcase
            end else if (lb_go) begin
                state     <= ST_LB_RUN;
                last_line <= win.line;
                last_ok   <= 1'b1;
            end
            if (pub_fire) begin
                src_ptr     <= src_ptr + 16'(BLK_BYTES);
                dst_off     <= dst_off + 13'(BLK_BYTES);
                blocks_left <= blocks_left - BW'(1);
                if (last_pub)
                    state <= (blocks_left == BW'(1)) ? ST_IDLE : ST_LB_WAIT;
            end
        end
    end

    assign rd_en   = wr_fire;
    assign wr_en   = wr_fire;
    assign rd_addr = run_src + 16'(byte_idx);
    assign wr_addr = {3'b100, run_dst + 13'(byte_idx)};
    assign wr_data = src_readable(rd_addr) ? rd_data : 8'hFF;
    assign status  = (state == ST_IDLE) ? {BW{1'b1}} : {1'b0, LEN_W'(blocks_left - BW'(1))};

endmodule

// File: rtl/vblk_dma_chk.sv
module vblk_dma_chk
    import vblk_dma_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         cfg_we,
    input logic         lcd_on,
    input logic [1:0]   disp_mode,
    input logic [7:0]   line_num,
    input logic [8:0]   line_dot,
    input logic [8:0]   blank_dot,
    input logic         wr_en,
    input logic         cpu_stall,
    input logic [LEN_W:0] status,
    input eng_state_t   st
);
    logic win_ok;
    assign win_ok = lcd_on && line_num < 8'd144 && disp_mode == 2'd0 &&
                    ({1'b0, line_dot} > {1'b0, blank_dot} + 10'd2);

    AST_WRITE_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> cpu_stall); // R4

    AST_WRITE_SPACING: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en); // R3

    AST_STATUS_FORM: assert property (@(posedge clk) disable iff (rst)
        status[LEN_W] |-> status == {(LEN_W+1){1'b1}}); // R5

    AST_STATUS_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_we) && $past(status) != {(LEN_W+1){1'b1}} &&
         status != {(LEN_W+1){1'b1}} && status != $past(status))
        |-> status == $past(status) - 1'b1); // R6

    AST_LCD_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LB_WAIT && !lcd_on && !cfg_we) |=> !cpu_stall); // R9

    AST_BLANK_GUARD: assert property (@(posedge clk) disable iff (rst)
        ($rose(cpu_stall) && $past(st) == ST_LB_WAIT) |-> $past(win_ok)); // R7

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !wr_en); // R11
endmodule

bind vblk_dma vblk_dma_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .lcd_on    (lcd_on),
    .disp_mode (disp_mode),
    .line_num  (line_num),
    .line_dot  (line_dot),
    .blank_dot (blank_dot),
    .wr_en     (wr_en),
    .cpu_stall (cpu_stall),
    .status    (status),
    .st        (state)
);

// File: tb/tb_vblk_dma.sv
`timescale 1ns/1ps
module tb_vblk_dma;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        lcd_on = 1'b1;
    logic [1:0]  disp_mode = 2'd2;
    logic [7:0]  line_num = 8'd0;
    logic [8:0]  line_dot = 9'd0;
    logic [8:0]  blank_dot = 9'd100;
    logic        dbl_speed = 1'b0;
    logic        rd_en, wr_en, cpu_stall;
    logic [15:0] rd_addr, wr_addr;
    logic [7:0]  rd_data, wr_data, status;
    logic [14:0] run_dots;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [15:0] a);
        if (a >= 16'h8000 && a <= 16'h9FFF) return 8'hFF;
        if (a >= 16'hE000) return 8'hFF;
        return mem_byte(a);
    endfunction

    assign rd_data = mem_byte(rd_addr);

    vblk_dma dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .lcd_on(lcd_on), .disp_mode(disp_mode), .line_num(line_num), .line_dot(line_dot),
        .blank_dot(blank_dot), .dbl_speed(dbl_speed), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_stall(cpu_stall), .status(status), .run_dots(run_dots)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [15:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle_watch(input int cyc, output bit seen);
        seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (cpu_stall || wr_en) seen = 1;
        end
    endtask

    // Trigger edge is the next posedge; k counts samples after it.
    task automatic watch_run(input int n, input bit dbl, input logic [15:0] s0, input logic [12:0] d0,
                             input logic [7:0] st_pre, input logic [7:0] st_fin, input bit poke,
                             input string dreq, input string tag);
        int d = dbl ? 4 : 2;
        int p = d;
        int t = d + (16 * n - 1) * p + 5;
        int kl = d + (16 * n - 1) * p + 12;
        int kend = kl + 3;
        int p0 = d + 15 * p + 12;
        int bs = 0, bw = 0, ba = 0, bd = 0, bt = 0;
        int sa = 0, se = 0, wa = 0, we_ = 0, aa = 0, ae = 0, da = 0, de = 0, ta = 0, te = 0;
        int exp_dots;
        @(posedge clk);
        for (int k = 1; k <= kend; k++) begin
            bit ew;
            int j, pubs;
            logic [7:0] est;
            @(negedge clk);
            if ((k <= t) !== cpu_stall && bs == 0) begin bs = 1; sa = cpu_stall; se = (k <= t); end
            ew = (k >= d) && ((k - d) % p == 0) && ((k - d) / p < 16 * n);
            j = (k - d) / p;
            if (wr_en !== ew) begin
                if (bw == 0) begin bw = 1; wa = wr_en; we_ = ew; end
            end else if (ew) begin
                logic [15:0] ea = {3'b100, d0 + 13'(j)};
                logic [7:0]  ed = exp_byte(s0 + 16'(j));
                if (wr_addr !== ea && ba == 0) begin ba = 1; aa = wr_addr; ae = ea; end
                if (wr_data !== ed && bd == 0) begin bd = 1; da = wr_data; de = ed; end
            end
            if (k - 1 < p0) pubs = 0;
            else begin
                pubs = (k - 1 - p0) / (16 * p) + 1;
                if (pubs > n) pubs = n;
            end
            est = (pubs == n) ? st_fin : st_pre - 8'(pubs);
            if (status !== est && bt == 0) begin bt = 1; ta = status; te = est; end
            cfg_we = 1'b0;
            if (poke && k == 6) begin cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h4320; end
            if (poke && k == 7) begin cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 16'h0005; end
        end
        cfg_we = 1'b0;
        exp_dots = dbl ? (t + 1) / 2 : t;
        check(bs == 0, "R4", {tag, " stall window"}, sa, se);
        check(bw == 0, "R3", {tag, " write timing"}, wa, we_);
        check(ba == 0, "R2", {tag, " write address"}, aa, ae);
        check(bd == 0, dreq, {tag, " write data"}, da, de);
        check(bt == 0, "R6", {tag, " status/publish"}, ta, te);
        check(run_dots == 15'(exp_dots), "R13", {tag, " run_dots"}, run_dots, exp_dots);
    endtask

    task automatic burst(input int n, input bit dbl, input bit wr_regs, input logic [15:0] sraw,
                         input logic [15:0] draw, input logic [15:0] s0, input logic [12:0] d0,
                         input bit poke, input string dreq, input string tag);
        dbl_speed = dbl;
        if (wr_regs) begin
            write_reg(2'd0, sraw);
            write_reg(2'd1, draw);
        end
        check(status == 8'hFF, "R5", {tag, " idle status"}, status, 8'hFF);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 16'(n - 1);
        watch_run(n, dbl, s0, d0, 8'(n - 1), 8'hFF, poke, dreq, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(status == 8'hFF, "R5", "reset status", status, 8'hFF);
        check(!cpu_stall && !wr_en, "R4", "reset quiet", {cpu_stall, wr_en}, 0);
        check(run_dots == 0, "R13", "reset run_dots", run_dots, 0);

        // R1 burst sweep over both speeds
        for (int s = 0; s < 2; s++) begin
            burst(1,   s[0], 1, 16'h123F, 16'hFFF7, 16'h1230, 13'h1FF0, 0, "R1", "R1 burst n1");
            burst(2,   s[0], 1, 16'h0400, 16'h1FF0, 16'h0400, 13'h1FF0, 0, "R1", "R2 burst wrap n2");
            burst(3,   s[0], 1, 16'h8800, 16'h0300, 16'h8800, 13'h0300, 0, "R12", "R12 burst vram src");
            burst(4,   s[0], 1, 16'hF000, 16'h0500, 16'hF000, 13'h0500, 0, "R12", "R12 burst high src");
            burst(128, s[0], 1, 16'h2000, 16'h0000, 16'h2000, 13'h0000, 0, "R1", "R1 burst n128");
        end
        // R6 pointers carry on; R11 writes during the run are ignored
        burst(1, 0, 0, 16'h0, 16'h0, 16'h2800, 13'h0800, 1, "R1", "R11 poke run");
        check(status == 8'hFF, "R11", "ctl write in run ignored", status, 8'hFF);
        burst(1, 0, 0, 16'h0, 16'h0, 16'h2810, 13'h0810, 0, "R11", "R11 after poke");

        // Line-blank mode
        dbl_speed = 1'b0;
        disp_mode = 2'd2; line_num = 8'd10; line_dot = 9'd200;
        write_reg(2'd0, 16'h3000);
        write_reg(2'd1, 16'h0200);
        write_reg(2'd2, 16'h0082);
        idle_watch(6, seen);
        check(!seen, "R7", "not in blank", seen, 0);
        check(status == 8'h02, "R5", "line-blank armed status", status, 8'h02);
        lcd_on = 1'b0; disp_mode = 2'd0;
        idle_watch(8, seen);
        check(!seen, "R9", "display off", seen, 0);
        lcd_on = 1'b1; line_num = 8'd150;
        idle_watch(8, seen);
        check(!seen, "R7", "line 150", seen, 0);
        line_num = 8'd144;
        idle_watch(8, seen);
        check(!seen, "R7", "line 144", seen, 0);
        line_num = 8'd10; line_dot = 9'd102;
        idle_watch(8, seen);
        check(!seen, "R7", "dot guard edge", seen, 0);
        line_dot = 9'd103;
        watch_run(1, 0, 16'h3000, 13'h0200, 8'h02, 8'h01, 0, "R1", "R7 blank block1");
        idle_watch(30, seen);
        check(!seen, "R8", "same line repeat", seen, 0);
        check(status == 8'h01, "R8", "status held", status, 8'h01);
        line_num = 8'd11;
        watch_run(1, 0, 16'h3010, 13'h0210, 8'h01, 8'h00, 0, "R1", "R8 next line");
        disp_mode = 2'd2; line_num = 8'd12;
        write_reg(2'd2, 16'h0000);
        check(status == 8'hFF, "R10", "cancel status", status, 8'hFF);
        disp_mode = 2'd0; line_num = 8'd13; line_dot = 9'd200;
        idle_watch(20, seen);
        check(!seen, "R10", "no block after cancel", seen, 0);

        disp_mode = 2'd2;
        write_reg(2'd0, 16'h5000);
        write_reg(2'd1, 16'h0400);
        write_reg(2'd2, 16'h0080);
        dbl_speed = 1'b1; disp_mode = 2'd0; line_num = 8'd20;
        watch_run(1, 1, 16'h5000, 13'h0400, 8'h00, 8'hFF, 0, "R1", "R3 double line-blank");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule